// File: doc/BRIEF.md
# Data-Space Address Generator

This block forms the effective address for every load and store of a small 8-bit controller core. A request carries an addressing mode, a pointer select, a 16-bit absolute address, a 6-bit offset and the current values of the three 16-bit pointer pairs. The pointer pairs live in the six highest registers of the register file: X is R27:R26, Y is R29:R28 and Z is R31:R30. The address it produces covers the whole data space: the register file, the I/O registers and the SRAM. The block does not hold the register file or the memory array.

Each access takes two cycles. In the first cycle (state CALC) the block computes the address from the request it captured. In the second cycle (state ACCESS) it presents that address as valid, and the memory reads or writes. The auto-update modes return a new pointer value to the register file through a write-back strobe during ACCESS. Pre-decrement uses the lowered pointer as the address. Post-increment uses the old pointer as the address and writes back the raised value. A request that is illegal moves the block to state FAULT for one cycle instead of ACCESS. The block raises an error flag there and performs no access and no write-back.

States and transitions: IDLE goes to CALC when a request is accepted. CALC goes to ACCESS when the request is legal, and to FAULT when it is illegal. ACCESS goes to IDLE. FAULT goes to IDLE.

Top module: `dspace_agu`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `addr_valid`, `ptr_wb_en` and `mode_err` are all 0.
- R2: Mode code 0 (absolute) sets the address to `req_direct`, over the full 16-bit range, and writes back no pointer.
- R3: Mode code 1 (pointer) sets the address to the selected pointer, and writes back no pointer. The pointer select codes are 0 = X, 1 = Y and 2 = Z.
- R4: Mode code 2 (offset) sets the address to the Y or Z pointer plus the zero-extended 6-bit `req_disp` (0 to 63), modulo 2^16, and writes back no pointer.
- R5: Mode code 3 (pre-decrement) sets both the address and the write-back value to the pointer minus 1, modulo 2^16, so 0x0000 becomes 0xFFFF.
- R6: Mode code 4 (post-increment) sets the address to the old pointer and the write-back value to the pointer plus 1, modulo 2^16, so 0xFFFF becomes 0x0000.
- R7: `ptr_wb_en` is high for exactly one cycle, in the ACCESS cycle of modes 3 and 4 only, with `ptr_wb_sel` equal to the pointer select code.
- R8: Three kinds of request are illegal: offset mode with X, pointer select code 3 in any pointer mode, and mode codes 5 to 7. For an illegal request, `mode_err` pulses for one cycle in the second cycle after acceptance, and neither `addr_valid` nor `ptr_wb_en` is asserted.
- R9: A request is accepted only in IDLE. `busy` is high for the two cycles after acceptance. `addr_valid` is high only in the second of them. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_mode | input | 3 | Addressing mode code |
| req_ptr | input | 2 | Pointer select code |
| req_direct | input | 16 | Absolute address |
| req_disp | input | 6 | Unsigned offset |
| ptr_x | input | 16 | Current X pointer |
| ptr_y | input | 16 | Current Y pointer |
| ptr_z | input | 16 | Current Z pointer |
| busy | output | 1 | Access sequence in progress |
| addr_valid | output | 1 | Effective address valid (ACCESS cycle) |
| eff_addr | output | 16 | Effective address |
| ptr_wb_en | output | 1 | Pointer write-back strobe |
| ptr_wb_sel | output | 2 | Pointer being written back |
| ptr_wb_data | output | 16 | Updated pointer value |
| mode_err | output | 1 | Illegal request flag |

## Verification
In the ACCESS cycle of the auto-update modes, the address and the pointer write-back appear together. Post-increment is the sharper case, because the address must carry the old pointer while the write-back carries the new one in the same cycle. The bench drives both update modes at the wrap points 0x0000 and 0xFFFF. Its monitor samples `eff_addr`, `ptr_wb_en` and `ptr_wb_data` in that one cycle and compares them with values queued from the requirements. A request held high through a busy sequence tests that acceptance does not overlap with an access in progress.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [2:0] {
        AM_DIRECT   = 3'd0,
        AM_INDIRECT = 3'd1,
        AM_DISP     = 3'd2,
        AM_PREDEC   = 3'd3,
        AM_POSTINC  = 3'd4
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_ACCESS = 2'd2,
        ST_FAULT  = 2'd3
    } agu_state_e;
endpackage

// File: rtl/agu_req_reg.sv
module agu_req_reg #(
    parameter int AW = 16,
    parameter int DW = 6,
    parameter int NP = 3,
    parameter int SW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [2:0]             mode_in,
    input  logic [SW-1:0]          sel_in,
    input  logic [AW-1:0]          direct_in,
    input  logic [DW-1:0]          disp_in,
    input  logic [NP-1:0][AW-1:0]  ptrs_in,
    output logic [2:0]             mode_q,
    output logic [SW-1:0]          sel_q,
    output logic [AW-1:0]          direct_q,
    output logic [DW-1:0]          disp_q,
    output logic [NP-1:0][AW-1:0]  ptrs_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            sel_q    <= '0;
            direct_q <= '0;
            disp_q   <= '0;
            ptrs_q   <= '0;
        end else if (load) begin
            mode_q   <= mode_in;
            sel_q    <= sel_in;
            direct_q <= direct_in;
            disp_q   <= disp_in;
            ptrs_q   <= ptrs_in;
        end
    end
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int           AW      = 16,
    parameter int           DW      = 6,
    parameter int           NP      = 3,
    parameter int           SW      = 2,
    parameter logic [NP-1:0] DISP_OK = 3'b110
) (
    input  logic [2:0]             mode,
    input  logic [SW-1:0]          sel,
    input  logic [AW-1:0]          direct,
    input  logic [DW-1:0]          disp,
    input  logic [NP-1:0][AW-1:0]  ptrs,
    output logic [AW-1:0]          ea,
    output logic [AW-1:0]          nxt,
    output logic                   upd,
    output logic                   bad
);
    logic [AW-1:0] base;
    logic          sel_ok;
    logic          disp_ok;

    always_comb begin
        base    = '0;
        sel_ok  = 1'b0;
        disp_ok = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (sel == SW'(i)) begin
                base    = ptrs[i];
                sel_ok  = 1'b1;
                disp_ok = DISP_OK[i];
            end
        end
    end

    always_comb begin
        ea  = base;
        nxt = base;
        upd = 1'b0;
        bad = 1'b0;
        case (mode)
            3'(AM_DIRECT): begin
                ea = direct;
            end
            3'(AM_INDIRECT): begin
                bad = !sel_ok;
            end
            3'(AM_DISP): begin
                ea  = base + AW'(disp);
                bad = !disp_ok;
            end
            3'(AM_PREDEC): begin
                nxt = base - AW'(1);
                ea  = nxt;
                upd = sel_ok;
                bad = !sel_ok;
            end
            3'(AM_POSTINC): begin
                nxt = base + AW'(1);
                upd = sel_ok;
                bad = !sel_ok;
            end
            default: begin
                bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl
    import agu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic calc_bad,
    output logic accept,
    output logic capture,
    output logic busy,
    output logic in_access,
    output logic in_fault
);
    agu_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_CALC;
            ST_CALC:   state_d = calc_bad ? ST_FAULT : ST_ACCESS;
            ST_ACCESS: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = 1'b0;
        capture   = 1'b0;
        busy      = 1'b0;
        in_access = 1'b0;
        in_fault  = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept = req_valid;
            ST_CALC:   begin busy = 1'b1; capture = 1'b1; end
            ST_ACCESS: begin busy = 1'b1; in_access = 1'b1; end
            ST_FAULT:  begin busy = 1'b1; in_fault = 1'b1; end
        endcase
    end

    // R9
    access_after_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCESS) |-> ($past(state_q) == ST_CALC));

    // R8
    fault_after_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |-> ($past(state_q) == ST_CALC));

    // R9
    calc_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC) |-> $past(accept));
endmodule

// File: rtl/dspace_agu.sv
module dspace_agu
    import agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_mode,
    input  logic [1:0]    req_ptr,
    input  logic [AW-1:0] req_direct,
    input  logic [DW-1:0] req_disp,
    input  logic [AW-1:0] ptr_x,
    input  logic [AW-1:0] ptr_y,
    input  logic [AW-1:0] ptr_z,
    output logic          busy,
    output logic          addr_valid,
    output logic [AW-1:0] eff_addr,
    output logic          ptr_wb_en,
    output logic [1:0]    ptr_wb_sel,
    output logic [AW-1:0] ptr_wb_data,
    output logic          mode_err
);
    localparam int NP = 3;
    localparam int SW = $clog2(NP + 1);

    logic                  accept, capture, in_access, in_fault;
    logic [2:0]            mode_q;
    logic [SW-1:0]         sel_q;
    logic [AW-1:0]         direct_q;
    logic [DW-1:0]         disp_q;
    logic [NP-1:0][AW-1:0] ptrs_in, ptrs_q;
    logic [AW-1:0]         calc_ea, calc_nxt;
    logic                  calc_upd, calc_bad;
    logic [AW-1:0]         ea_q, nxt_q;
    logic                  upd_q;
    logic [SW-1:0]         wsel_q;
    logic [2:0]            amode_q;

    assign ptrs_in = {ptr_z, ptr_y, ptr_x};

    agu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .calc_bad  (calc_bad),
        .accept    (accept),
        .capture   (capture),
        .busy      (busy),
        .in_access (in_access),
        .in_fault  (in_fault)
    );

    agu_req_reg #(.AW(AW), .DW(DW), .NP(NP), .SW(SW)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .mode_in   (req_mode),
        .sel_in    (SW'(req_ptr)),
        .direct_in (req_direct),
        .disp_in   (req_disp),
        .ptrs_in   (ptrs_in),
        .mode_q    (mode_q),
        .sel_q     (sel_q),
        .direct_q  (direct_q),
        .disp_q    (disp_q),
        .ptrs_q    (ptrs_q)
    );

    agu_addr_calc #(.AW(AW), .DW(DW), .NP(NP), .SW(SW)) u_calc (
        .mode   (mode_q),
        .sel    (sel_q),
        .direct (direct_q),
        .disp   (disp_q),
        .ptrs   (ptrs_q),
        .ea     (calc_ea),
        .nxt    (calc_nxt),
        .upd    (calc_upd),
        .bad    (calc_bad)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q    <= '0;
            nxt_q   <= '0;
            upd_q   <= 1'b0;
            wsel_q  <= '0;
            amode_q <= '0;
        end else if (capture) begin
            ea_q    <= calc_ea;
            nxt_q   <= calc_nxt;
            upd_q   <= calc_upd && !calc_bad;
            wsel_q  <= sel_q;
            amode_q <= mode_q;
        end
    end

    assign addr_valid  = in_access;
    assign eff_addr    = ea_q;
    assign ptr_wb_en   = in_access && upd_q;
    assign ptr_wb_sel  = 2'(wsel_q);
    assign ptr_wb_data = nxt_q;
    assign mode_err    = in_fault;

    // R7
    wb_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wb_en |-> addr_valid);

    // R7
    wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wb_en |=> !ptr_wb_en);

    // R8
    err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (!addr_valid && !ptr_wb_en));

    // R5
    predec_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wb_en && amode_q == 3'(AM_PREDEC)) |-> (eff_addr == ptr_wb_data));

    // R6
    postinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wb_en && amode_q == 3'(AM_POSTINC)) |-> (ptr_wb_data == eff_addr + AW'(1)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!addr_valid && !mode_err && !ptr_wb_en));
endmodule

// File: tb/sim_dspace_agu.sv
module sim_dspace_agu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_ptr = '0;
    logic [15:0] req_direct = '0;
    logic [5:0]  req_disp = '0;
    logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
    logic        busy, addr_valid, ptr_wb_en, mode_err;
    logic [15:0] eff_addr, ptr_wb_data;
    logic [1:0]  ptr_wb_sel;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] ea;
        logic [15:0] wbd;
        logic [1:0]  sel;
        logic        wb;
        logic        err;
        int          rq;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dspace_agu u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_ptr(req_ptr), .req_direct(req_direct), .req_disp(req_disp),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .busy(busy),
        .addr_valid(addr_valid), .eff_addr(eff_addr), .ptr_wb_en(ptr_wb_en),
        .ptr_wb_sel(ptr_wb_sel), .ptr_wb_data(ptr_wb_data), .mode_err(mode_err)
    );

    function automatic exp_t model(input logic [2:0] m, input logic [1:0] p,
                                   input logic [15:0] d, input logic [5:0] o,
                                   input logic [15:0] x, input logic [15:0] y,
                                   input logic [15:0] z, input int rq);
        exp_t e;
        logic [15:0] b;
        b = (p == 2'd0) ? x : (p == 2'd1) ? y : z;
        e.ea = b; e.wbd = b; e.sel = p; e.wb = 1'b0; e.err = 1'b0; e.rq = rq;
        if (m >= 3'd5 || (m != 3'd0 && p == 2'd3) || (m == 3'd2 && p == 2'd0))
            e.err = 1'b1;
        else if (m == 3'd0) e.ea = d;
        else if (m == 3'd2) e.ea = b + {10'd0, o};
        else if (m == 3'd3) begin e.ea = b - 16'd1; e.wbd = b - 16'd1; e.wb = 1'b1; end
        else if (m == 3'd4) begin e.wbd = b + 16'd1; e.wb = 1'b1; end
        return e;
    endfunction

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per ACCESS or FAULT cycle
    always @(negedge clk) begin
        if (rst_n && !done && (addr_valid || mode_err || ptr_wb_en)) begin
            if (sb.size() == 0) begin
                check(1'b0, 9, "unexpected access", {15'd0, addr_valid, eff_addr}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(mode_err === e.err && addr_valid === !e.err, e.rq, "err/valid",
                      {30'd0, mode_err, addr_valid}, {30'd0, e.err, !e.err});
                check(ptr_wb_en === e.wb, e.rq, "wb_en", {31'd0, ptr_wb_en}, {31'd0, e.wb});
                if (!e.err)
                    check(eff_addr === e.ea, e.rq, "eff_addr", {16'd0, eff_addr}, {16'd0, e.ea});
                if (e.wb)
                    check(ptr_wb_data === e.wbd && ptr_wb_sel === e.sel, e.rq, "wb data/sel",
                          {14'd0, ptr_wb_sel, ptr_wb_data}, {14'd0, e.sel, e.wbd});
            end
        end
    end

    // driver: one request, sequencing checked against R9
    task automatic issue(input logic [2:0] m, input logic [1:0] p, input logic [15:0] d,
                         input logic [5:0] o, input logic [15:0] x, input logic [15:0] y,
                         input logic [15:0] z, input int rq, input bit hold);
        @(negedge clk);
        req_mode = m; req_ptr = p; req_direct = d; req_disp = o;
        ptr_x = x; ptr_y = y; ptr_z = z; req_valid = 1'b1;
        sb.push_back(model(m, p, d, o, x, y, z, rq));
        @(negedge clk);
        if (hold) begin
            req_mode = 3'd0; req_direct = 16'h1234;
        end else req_valid = 1'b0;
        check(busy === 1'b1 && addr_valid === 1'b0, 9, "calc cycle busy/valid",
              {30'd0, busy, addr_valid}, 32'b10);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, 9, "second cycle busy", {31'd0, busy}, 32'd1);
        @(negedge clk);
        check(busy === 1'b0 && !addr_valid && !ptr_wb_en && !mode_err, 9, "back to idle",
              {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !addr_valid && !ptr_wb_en && !mode_err, 1, "in reset",
              {28'd0, busy, addr_valid, ptr_wb_en, mode_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !addr_valid && !ptr_wb_en && !mode_err, 1, "after reset",
              {28'd0, busy, addr_valid, ptr_wb_en, mode_err}, 32'd0);
        // R2 absolute
        issue(3'd0, 2'd1, 16'hBEEF, 6'd5, 16'h1111, 16'h2222, 16'h3333, 2, 1'b0);
        issue(3'd0, 2'd3, 16'hFFFF, 6'd0, 16'h0, 16'h0, 16'h0, 2, 1'b0);
        // R3 pointer
        issue(3'd1, 2'd0, 16'h0, 6'd0, 16'h00A5, 16'h2222, 16'h3333, 3, 1'b0);
        issue(3'd1, 2'd2, 16'h0, 6'd0, 16'h1111, 16'h2222, 16'hC0DE, 3, 1'b0);
        // R4 offset
        issue(3'd2, 2'd1, 16'h0, 6'd0, 16'h1111, 16'h0200, 16'h3333, 4, 1'b0);
        issue(3'd2, 2'd2, 16'h0, 6'd63, 16'h1111, 16'h2222, 16'h0100, 4, 1'b0);
        issue(3'd2, 2'd2, 16'h0, 6'd63, 16'h1111, 16'h2222, 16'hFFF0, 4, 1'b0);
        // R5 pre-decrement, wrap and plain
        issue(3'd3, 2'd0, 16'h0, 6'd0, 16'h0000, 16'h2222, 16'h3333, 5, 1'b0);
        issue(3'd3, 2'd1, 16'h0, 6'd0, 16'h1111, 16'h0100, 16'h3333, 5, 1'b0);
        // R6 post-increment, wrap and plain
        issue(3'd4, 2'd2, 16'h0, 6'd0, 16'h1111, 16'h2222, 16'hFFFF, 6, 1'b0);
        issue(3'd4, 2'd0, 16'h0, 6'd0, 16'h0060, 16'h2222, 16'h3333, 7, 1'b0);
        // R8 illegal requests
        issue(3'd2, 2'd0, 16'h0, 6'd9, 16'h1111, 16'h2222, 16'h3333, 8, 1'b0);
        issue(3'd6, 2'd1, 16'h0, 6'd0, 16'h1111, 16'h2222, 16'h3333, 8, 1'b0);
        issue(3'd1, 2'd3, 16'h0, 6'd0, 16'h1111, 16'h2222, 16'h3333, 8, 1'b0);
        issue(3'd3, 2'd3, 16'h0, 6'd0, 16'h1111, 16'h2222, 16'h3333, 8, 1'b0);
        // R9 request held while busy is ignored
        issue(3'd4, 2'd1, 16'h0, 6'd0, 16'h1111, 16'h7000, 16'h3333, 9, 1'b1);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, 9, "queue drained", sb.size(), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL R9 watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule